// File: doc/BRIEF.md
# Socket Command and Interrupt Unit

This block holds the control registers of one network socket: a command register, an interrupt status register and an interrupt mask register. It drives an active-low interrupt line to the host. The host writes a nonzero command code through a simple synchronous register port. The block latches the code and announces it to the protocol engine with a one-cycle valid pulse. When the engine signals acceptance, the block returns the register to zero, even though the command may still be running. Completion is reported only through the interrupt status bits, never through the command register.

The protocol engine raises events on eight single-cycle pulse inputs. Each pulse sets a sticky status bit, and the host clears a bit by writing a one to its position. The interrupt line goes low whenever a status bit and its mask bit are both set.

The command path uses a valid/accept pair without back-pressure on the valid side. `cmd_valid` is a pulse, not a level. The engine may assert `cmd_accept` on any later cycle. Until it does, the register stays nonzero, and further host command writes are dropped. The host therefore sees back-pressure as a nonzero command read-back.

Top module: `sock_cmd_irq`

## Requirements
- R1: After reset, the command, mask and status registers read 0, `cmd_valid` is low and `irq_n` is high.
- R2: A host write of a nonzero code to the command register (address 0), while the register reads 0, has two results. The register holds that code from the next cycle on. `cmd_valid` is high for exactly one cycle, the one after the write, with `cmd_code` equal to the code.
- R3: A host write of 0x00 to the command register is ignored. The register is unchanged and no `cmd_valid` pulse follows.
- R4: `cmd_accept` while the command register is nonzero clears it to 0 from the next cycle. `cmd_accept` while it is zero has no effect.
- R5: A host command write while the command register is nonzero is ignored. No pulse follows and the held code is unchanged.
- R6: A pulse on `evt[i]` sets status bit i, and the bit stays set until the host clears it. The bit assignment is 7 PPP receive, 6 PPP fail, 5 PPP next phase, 4 send done, 3 timeout, 2 data received, 1 disconnected, 0 connected.
- R7: A host write to the status register (address 2) clears every status bit written as one and leaves every bit written as zero unchanged.
- R8: If an event on bit i arrives in the same cycle as a host clear of bit i, the bit stays set.
- R9: Bits 15 to 8 of the command, mask and status read-back are always zero, whatever was written there.
- R10: A write to address 1 loads the mask from bits 7 to 0. `irq_n` is low exactly when some status bit and its mask bit are both set.
- R11: Reads of address 3 return 0, and writes to address 3 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| addr | input | 2 | Register select: 0 command, 1 mask, 2 status, 3 none |
| wr_data | input | 16 | Host write data |
| rd_data | output | 16 | Read-back of the selected register (combinational) |
| cmd_valid | output | 1 | One-cycle pulse announcing a new command |
| cmd_code | output | 8 | Currently held command code |
| cmd_accept | input | 1 | Engine accepts the pending command |
| evt | input | 8 | Event pulses from the protocol engine |
| irq_n | output | 1 | Active-low host interrupt |

## Verification
The two functions that can fall in the same cycle are the setting of a status bit by an engine event and the clearing of that bit by a host write-one. The bench drives an event on each bit and a clear of all bits on the same clock edge. It then expects exactly that bit to remain set and the rest to be cleared. A second overlap also applies: a host command write in the same cycle as `cmd_accept` while a code is pending. The bench expects the new write to be dropped and the register to read zero afterwards.

// File: rtl/sock_ci_pkg.sv
package sock_ci_pkg;
  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_MASK = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // status bit positions
  localparam int EV_CONN  = 0;
  localparam int EV_DISC  = 1;
  localparam int EV_RECV  = 2;
  localparam int EV_TMO   = 3;
  localparam int EV_SENT  = 4;
  localparam int EV_PNEXT = 5;
  localparam int EV_PFAIL = 6;
  localparam int EV_PRECV = 7;
endpackage

// File: rtl/sock_cmd_latch.sv
module sock_cmd_latch #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              accept,
  output logic [CODE_W-1:0] code_q,
  output logic              valid_q
);
  logic pending;
  logic load;

  assign pending = |code_q;
  assign load    = wr_stb && (|wr_code) && !pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= load;
      if (load)
        code_q <= wr_code;
      else if (accept && pending)
        code_q <= '0;
    end
  end

  // R2
  pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
  // R4
  accept_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && code_q != '0) |=> code_q == '0);
  // R3
  zero_write_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_code == '0) |=> !valid_q);
  // R5
  busy_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && code_q != '0) |=> (!valid_q && (code_q == '0 || $stable(code_q))));
endmodule

// File: rtl/sock_irq_bank.sv
module sock_irq_bank #(
  parameter int EVT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] evt,
  input  logic             clr_stb,
  input  logic [EVT_W-1:0] clr_bits,
  input  logic             mask_stb,
  input  logic [EVT_W-1:0] mask_bits,
  output logic [EVT_W-1:0] stat_q,
  output logic [EVT_W-1:0] mask_q,
  output logic             irq_n
);
  always_ff @(posedge clk) begin
    if (!rst_n)        mask_q <= '0;
    else if (mask_stb) mask_q <= mask_bits;
  end

  for (genvar i = 0; i < EVT_W; i++) begin : g_bit
    logic clr_i;
    assign clr_i = clr_stb && clr_bits[i];

    always_ff @(posedge clk) begin
      if (!rst_n) stat_q[i] <= 1'b0;
      else        stat_q[i] <= evt[i] | (stat_q[i] & ~clr_i);
    end

    // R8
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> stat_q[i]);
    // R7
    clear_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !evt[i]) |=> !stat_q[i]);
    // R6
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[i] && !clr_i) |=> stat_q[i]);
  end

  assign irq_n = ~|(stat_q & mask_q);

  // R10
  irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_stb && mask_bits == '0) |=> irq_n);
endmodule

// File: rtl/sock_cmd_irq.sv
module sock_cmd_irq
  import sock_ci_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CODE_W = 8,
  parameter int EVT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              cmd_valid,
  output logic [CODE_W-1:0] cmd_code,
  input  logic              cmd_accept,
  input  logic [EVT_W-1:0]  evt,
  output logic              irq_n
);
  localparam int CPAD = DATA_W - CODE_W;
  localparam int EPAD = DATA_W - EVT_W;

  reg_sel_e         sel;
  logic [EVT_W-1:0] stat_q;
  logic [EVT_W-1:0] mask_q;
  logic             unused_hi;

  assign sel       = reg_sel_e'(addr);
  assign unused_hi = ^wr_data[DATA_W-1:CODE_W];

  sock_cmd_latch #(.CODE_W(CODE_W)) u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (wr_en && sel == SEL_CMD),
    .wr_code (wr_data[CODE_W-1:0]),
    .accept  (cmd_accept),
    .code_q  (cmd_code),
    .valid_q (cmd_valid)
  );

  sock_irq_bank #(.EVT_W(EVT_W)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (evt),
    .clr_stb   (wr_en && sel == SEL_STAT),
    .clr_bits  (wr_data[EVT_W-1:0]),
    .mask_stb  (wr_en && sel == SEL_MASK),
    .mask_bits (wr_data[EVT_W-1:0]),
    .stat_q    (stat_q),
    .mask_q    (mask_q),
    .irq_n     (irq_n)
  );

  always_comb begin
    case (sel)
      SEL_CMD:  rd_data = {{CPAD{1'b0}}, cmd_code};
      SEL_MASK: rd_data = {{EPAD{1'b0}}, mask_q};
      SEL_STAT: rd_data = {{EPAD{1'b0}}, stat_q};
      default:  rd_data = '0;
    endcase
  end

  // R9
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DATA_W-1:CODE_W] == '0);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (irq_n && !cmd_valid && cmd_code == '0));
endmodule

// File: tb/sock_cmd_irq_bench.sv
module sock_cmd_irq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd3;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        cmd_valid;
  logic [7:0]  cmd_code;
  logic        cmd_accept = 1'b0;
  logic [7:0]  evt = '0;
  logic        irq_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  sock_cmd_irq u_sock_cmd_irq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_accept(cmd_accept), .evt(evt), .irq_n(irq_n)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, return at the following negedge
  task automatic cyc(input logic we, input logic [1:0] a, input logic [15:0] d,
                     input logic acc, input logic [7:0] e);
    @(negedge clk);
    wr_en = we; addr = a; wr_data = d; cmd_accept = acc; evt = e;
    @(negedge clk);
    wr_en = 1'b0; cmd_accept = 1'b0; evt = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    addr = a;
    #1 v = rd_data;
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(2'd0, v); chk("R1 cmd", v, 16'h0);
    rd(2'd1, v); chk("R1 mask", v, 16'h0);
    rd(2'd2, v); chk("R1 status", v, 16'h0);
    chk("R1 irq_n", {15'b0, irq_n}, 16'h1);
    chk("R1 cmd_valid", {15'b0, cmd_valid}, 16'h0);

    // R2 / R4 / R9: sweep every nonzero code, junk in upper byte
    for (int c = 1; c < 256; c++) begin
      cyc(1'b1, 2'd0, {8'hA5, 8'(c)}, 1'b0, 8'h0);
      chk("R2 pulse", {15'b0, cmd_valid}, 16'h1);
      chk("R2 code", {8'h0, cmd_code}, 16'(c));
      rd(2'd0, v); chk("R9 cmd readback", v, 16'(c));
      @(negedge clk);
      chk("R2 pulse ends", {15'b0, cmd_valid}, 16'h0);
      cyc(1'b0, 2'd0, 16'h0, 1'b1, 8'h0);
      rd(2'd0, v); chk("R4 cleared", v, 16'h0);
    end

    // R3 zero write ignored
    cyc(1'b1, 2'd0, 16'hFF00, 1'b0, 8'h0);
    chk("R3 no pulse", {15'b0, cmd_valid}, 16'h0);
    rd(2'd0, v); chk("R3 still zero", v, 16'h0);

    // R4 accept while idle has no effect
    cyc(1'b0, 2'd0, 16'h0, 1'b1, 8'h0);
    rd(2'd0, v); chk("R4 idle accept", v, 16'h0);

    // R5 write while pending dropped
    cyc(1'b1, 2'd0, 16'h0011, 1'b0, 8'h0);
    @(negedge clk);
    cyc(1'b1, 2'd0, 16'h0022, 1'b0, 8'h0);
    chk("R5 no pulse", {15'b0, cmd_valid}, 16'h0);
    rd(2'd0, v); chk("R5 code kept", v, 16'h0011);
    // R5 write in same cycle as accept: dropped, register clears
    cyc(1'b1, 2'd0, 16'h0033, 1'b1, 8'h0);
    chk("R5 accept overlap no pulse", {15'b0, cmd_valid}, 16'h0);
    rd(2'd0, v); chk("R5 accept overlap cleared", v, 16'h0);

    // R6: each event sets only its own bit, sticky
    for (int i = 0; i < 8; i++) begin
      cyc(1'b0, 2'd3, 16'h0, 1'b0, 8'(1 << i));
      @(negedge clk);
      rd(2'd2, v); chk("R6 sticky bit", v, 16'(1 << i));
      cyc(1'b1, 2'd2, 16'hFFFF, 1'b0, 8'h0);
      rd(2'd2, v); chk("R7 clear all", v, 16'h0);
    end

    // R7: every clear pattern against a full status
    for (int p = 0; p < 256; p++) begin
      cyc(1'b0, 2'd3, 16'h0, 1'b0, 8'hFF);
      cyc(1'b1, 2'd2, {8'hFF, 8'(p)}, 1'b0, 8'h0);
      rd(2'd2, v); chk("R7 partial clear", v, {8'h0, ~8'(p)});
    end
    cyc(1'b1, 2'd2, 16'h00FF, 1'b0, 8'h0);

    // R8: event and clear on the same edge
    for (int i = 0; i < 8; i++) begin
      cyc(1'b0, 2'd3, 16'h0, 1'b0, 8'hFF);
      cyc(1'b1, 2'd2, 16'h00FF, 1'b0, 8'(1 << i));
      rd(2'd2, v); chk("R8 event wins", v, 16'(1 << i));
      cyc(1'b1, 2'd2, 16'h00FF, 1'b0, 8'h0);
    end

    // R10: every mask against every single status bit
    for (int i = 0; i < 8; i++) begin
      cyc(1'b0, 2'd3, 16'h0, 1'b0, 8'(1 << i));
      for (int m = 0; m < 256; m++) begin
        cyc(1'b1, 2'd1, {8'h5A, 8'(m)}, 1'b0, 8'h0);
        chk("R10 irq_n", {15'b0, irq_n}, {15'b0, ((m >> i) & 1) == 0});
      end
      rd(2'd1, v); chk("R9 mask readback", v, 16'h00FF);
      cyc(1'b1, 2'd2, 16'h00FF, 1'b0, 8'h0);
      chk("R10 irq released", {15'b0, irq_n}, 16'h1);
    end

    // R11: address 3 reads zero and writes touch nothing
    cyc(1'b0, 2'd3, 16'h0, 1'b0, 8'h0F);
    cyc(1'b1, 2'd3, 16'hFFFF, 1'b0, 8'h0);
    rd(2'd3, v); chk("R11 read zero", v, 16'h0);
    rd(2'd2, v); chk("R11 status kept", v, 16'h000F);
    rd(2'd1, v); chk("R11 mask kept", v, 16'h00FF);
    rd(2'd0, v); chk("R11 cmd kept", v, 16'h0);
    chk("R11 no pulse", {15'b0, cmd_valid}, 16'h0);

    // R1: reset again from a busy state
    cyc(1'b1, 2'd0, 16'h0044, 1'b0, 8'h0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd(2'd0, v); chk("R1 cmd after reset", v, 16'h0);
    rd(2'd2, v); chk("R1 status after reset", v, 16'h0);
    chk("R1 irq_n after reset", {15'b0, irq_n}, 16'h1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule